// File: doc/BRIEF.md
# Mantissa Rounding Stage

This block finishes the rounding of a floating-point result. It receives an unsigned mantissa whose two lowest bits are the guard bit (upper) and the round bit (lower). It also receives a separate sticky bit, the sign of the value and a two-bit rounding-mode code. It drops the guard and round bits. When the selected mode calls for it, it adds one to what remains, and the carry can ripple through every bit.

The rounded mantissa keeps one extra bit at the top, so a carry out of the full mantissa is never lost. The result can therefore be one position above the normal leading-one bit. The stage reports whether it added one, so the caller can adjust the exponent and renormalize. It also reports whether any precision was discarded. The stage leaves exponent selection, renormalization and packing to the caller. Results are registered once, so each output reflects the inputs present at the previous rising clock edge.

Top module: `mant_round`

## Requirements
- R1: While `rst_n` is low, `mant_o`, `rnd_up_o` and `inexact_o` are all zero.
- R2: Let the truncated value be `mant_i` shifted right by two bits and zero-extended by one bit. When `rnd_up_o` is 0, `mant_o` equals this truncated value.
- R3: If `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all zero, the stage does not increment and `inexact_o` is 0, in every mode.
- R4: If any of guard, round or sticky is 1, `inexact_o` is 1, in every mode.
- R5: With `mode_i` = 0 (nearest, ties to even), the stage never increments when guard is 0. When guard is 1, it increments if round is 1, sticky is 1, or `mant_i[2]` (the LSB after the shift) is 1.
- R6: With `mode_i` = 1 (toward zero), the stage never increments.
- R7: The directed modes increment only on an inexact result, as follows:
  - With `mode_i` = 2 (toward plus infinity), the stage increments only when `sign_i` is 0.
  - With `mode_i` = 3 (toward minus infinity), the stage increments only when `sign_i` is 1.
- R8: The increment carries through all bits. For example, truncated value 0x3FFFFF plus one gives `mant_o` = 0x400000, which sets the extra top bit. This value is not corrected.
- R9: `rnd_up_o` is 1 exactly when the increment was applied. `mant_o` always equals the truncated value plus `rnd_up_o`.
- R10: The outputs change only at a rising clock edge. They show the result for the inputs sampled at the most recent edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-1 | Rounded mantissa including the carry-out bit |
| rnd_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Guard, round or sticky was nonzero |

## Verification
The bound checker checks these properties on every clock edge:
- The output always equals the truncated input plus the increment flag.
- An exact input never increments and never raises inexact, and any discarded bit raises inexact.
- The toward-zero mode never increments, and each directed mode never increments for the wrong sign.
- The nearest mode never increments when guard is clear.

Only the bench scenarios can show the following:
- The tie cases that resolve to even, in both directions.
- The full carry ripple up to the extra top bit.
- The reset values.
- The one-cycle latency.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_TO_POS    = 2'd2,
        RM_TO_NEG    = 2'd3
    } rmode_e;
endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_round_pkg::*;
(
    input  logic   guard,
    input  logic   rbit,
    input  logic   sticky,
    input  logic   lsb,
    input  logic   neg,
    input  rmode_e mode,
    output logic   inc,
    output logic   inexact
);
    always_comb begin
        inexact = guard | rbit | sticky;
        inc     = 1'b0;
        if (inexact) begin
            unique case (mode)
                RM_NEAR_EVEN: inc = guard & (rbit | sticky | lsb);
                RM_TO_ZERO:   inc = 1'b0;
                RM_TO_POS:    inc = ~neg;
                RM_TO_NEG:    inc = neg;
                default:      inc = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr #(
    parameter int W = 22
) (
    input  logic [W-1:0] a,
    input  logic         inc,
    output logic [W:0]   sum
);
    logic [W:0] carry;
    assign carry[0] = inc;
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign sum[gi]      = a[gi] ^ carry[gi];
        assign carry[gi+1]  = a[gi] & carry[gi];
    end
    assign sum[W] = carry[W];
endmodule

// File: rtl/mant_round.sv
module mant_round
    import mant_round_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-2:0] mant_o,
    output logic              rnd_up_o,
    output logic              inexact_o
);
    localparam int TW = MANT_W - 2;   // truncated width
    localparam int OW = TW + 1;       // output width with carry bit

    typedef struct packed {
        logic [OW-1:0] mant;
        logic          up;
        logic          inx;
    } res_t;

    res_t          res_d, res_q;
    logic [TW-1:0] trunc_w;
    logic [OW-1:0] sum_w;
    logic          inc_w, inx_w;

    assign trunc_w = mant_i[MANT_W-1:2];

    mant_round_decide u_decide (
        .guard   (mant_i[1]),
        .rbit    (mant_i[0]),
        .sticky  (sticky_i),
        .lsb     (mant_i[2]),
        .neg     (sign_i),
        .mode    (rmode_e'(mode_i)),
        .inc     (inc_w),
        .inexact (inx_w)
    );

    mant_round_incr #(.W(TW)) u_incr (
        .a   (trunc_w),
        .inc (inc_w),
        .sum (sum_w)
    );

    always_comb begin
        res_d.mant = sum_w;
        res_d.up   = inc_w;
        res_d.inx  = inx_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign mant_o    = res_q.mant;
    assign rnd_up_o  = res_q.up;
    assign inexact_o = res_q.inx;
endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
    parameter int MANT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MANT_W-1:0] mant_i,
    input logic              sticky_i,
    input logic              sign_i,
    input logic [1:0]        mode_i,
    input logic [MANT_W-2:0] mant_o,
    input logic              rnd_up_o,
    input logic              inexact_o
);
    localparam int OW = MANT_W - 1;
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r3_exact_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(mant_i[1:0]) == 2'b00) && !$past(sticky_i)
        |-> !rnd_up_o && !inexact_o);

    a_r4_inexact_set: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && (($past(mant_i[1:0]) != 2'b00) || $past(sticky_i))
        |-> inexact_o);

    a_r5_near_no_guard: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(mode_i) == 2'd0) && !$past(mant_i[1])
        |-> !rnd_up_o);

    a_r6_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(mode_i) == 2'd1) |-> !rnd_up_o);

    a_r7_pos_mode_neg: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(mode_i) == 2'd2) && $past(sign_i) |-> !rnd_up_o);

    a_r7_neg_mode_pos: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(mode_i) == 2'd3) && !$past(sign_i) |-> !rnd_up_o);

    a_r9_sum_match: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> mant_o == ({1'b0, $past(mant_i[MANT_W-1:2])} + OW'(rnd_up_o)));
endmodule

bind mant_round mant_round_chk #(.MANT_W(MANT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mant_i    (mant_i),
    .sticky_i  (sticky_i),
    .sign_i    (sign_i),
    .mode_i    (mode_i),
    .mant_o    (mant_o),
    .rnd_up_o  (rnd_up_o),
    .inexact_o (inexact_o)
);

// File: tb/mant_round_tb.sv
module mant_round_tb;
    localparam int MANT_W = 24;
    localparam int NV = 16;
    // {mant[23:0], sticky, sign, mode[1:0], exp_mant[22:0], exp_up, exp_inx}
    localparam logic [52:0] VEC [NV] = '{
        {24'h000010, 1'b0, 1'b0, 2'd0, 23'h000004, 1'b0, 1'b0}, // R3 exact
        {24'h000012, 1'b0, 1'b0, 2'd0, 23'h000004, 1'b0, 1'b1}, // R5 tie even stays
        {24'h000016, 1'b0, 1'b0, 2'd0, 23'h000006, 1'b1, 1'b1}, // R5 tie odd goes up
        {24'h000013, 1'b0, 1'b0, 2'd0, 23'h000005, 1'b1, 1'b1}, // R5 guard+round
        {24'h000012, 1'b1, 1'b0, 2'd0, 23'h000005, 1'b1, 1'b1}, // R5 guard+sticky
        {24'h000011, 1'b1, 1'b0, 2'd0, 23'h000004, 1'b0, 1'b1}, // R5 guard clear
        {24'h000017, 1'b1, 1'b0, 2'd1, 23'h000005, 1'b0, 1'b1}, // R6
        {24'h000011, 1'b0, 1'b0, 2'd2, 23'h000005, 1'b1, 1'b1}, // R7 +inf pos
        {24'h000011, 1'b0, 1'b1, 2'd2, 23'h000004, 1'b0, 1'b1}, // R7 +inf neg
        {24'h000011, 1'b0, 1'b1, 2'd3, 23'h000005, 1'b1, 1'b1}, // R7 -inf neg
        {24'h000011, 1'b0, 1'b0, 2'd3, 23'h000004, 1'b0, 1'b1}, // R7 -inf pos
        {24'h000010, 1'b0, 1'b1, 2'd3, 23'h000004, 1'b0, 1'b0}, // R3 directed exact
        {24'hFFFFFF, 1'b0, 1'b0, 2'd0, 23'h400000, 1'b1, 1'b1}, // R8 full carry
        {24'hFFFFFC, 1'b1, 1'b0, 2'd2, 23'h400000, 1'b1, 1'b1}, // R8 sticky carry
        {24'hFFFFFC, 1'b0, 1'b0, 2'd2, 23'h3FFFFF, 1'b0, 1'b0}, // R2 exact max
        {24'h000000, 1'b1, 1'b0, 2'd1, 23'h000000, 1'b0, 1'b1}  // R4 sticky only
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MANT_W-1:0] mant_i = '0;
    logic              sticky_i = 1'b0;
    logic              sign_i = 1'b0;
    logic [1:0]        mode_i = 2'd0;
    logic [MANT_W-2:0] mant_o;
    logic              rnd_up_o, inexact_o;
    int                n_run = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    mant_round #(.MANT_W(MANT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mant_i(mant_i), .sticky_i(sticky_i),
        .sign_i(sign_i), .mode_i(mode_i), .mant_o(mant_o),
        .rnd_up_o(rnd_up_o), .inexact_o(inexact_o)
    );

    task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [52:0] v);
        @(negedge clk);
        mant_i   = v[52:29];
        sticky_i = v[28];
        sign_i   = v[27];
        mode_i   = v[26:25];
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        mant_i = 24'hFFFFFF; sticky_i = 1'b1; mode_i = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {mant_o, rnd_up_o, inexact_o}, 25'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R2/R9 vec%0d", i), {mant_o, rnd_up_o, inexact_o}, VEC[i][24:0]);
        end

        // R10: new inputs must not show before the next edge
        apply(VEC[2]);
        @(negedge clk);
        mant_i = 24'h000010; sticky_i = 1'b0; mode_i = 2'd0;
        #1;
        check("R10 hold", {mant_o, rnd_up_o, inexact_o}, VEC[2][24:0]);
        @(posedge clk); #1;
        check("R10 update", {mant_o, rnd_up_o, inexact_o}, {23'h000004, 1'b0, 1'b0});

        // R1: asynchronous reset clears mid-run
        apply(VEC[12]);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async clear", {mant_o, rnd_up_o, inexact_o}, 25'd0);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule